// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital sequencer for a single-wire LIN bus transceiver. It tracks four states: power-down, sleep, a transitional awake state, and normal operation. From the current state it decides whether transmit data may reach the bus, what the receive-data pin shows, whether the external regulator is switched on, and whether the pull-up on the transmit input is powered. The analog parts are represented only as digital signals: a supply-good flag, a bus-level bit (1 = recessive) and wake requests from the bus and the wake pin.

At power-up, or on a remote wake, the controller enters the awake state. In that state it turns the regulator on and holds the receive output low. It stays there until the host confirms by raising its enable line. The enable input is asynchronous and passes through a two-stage synchroniser before the state machine uses it.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted, the mode is power-down (`mode`=2'b00) and `inh_out`, `rxd_oe`, `txd_pu_en`, `tx_path_en` and `bus_pull_dom` are all 0.
- R2: In power-down with `supply_ok`=1, the mode becomes awake (2'b10) on the next rising edge, whatever the enable input is.
- R3: When `supply_ok`=0, the mode becomes power-down on the next rising edge from any mode. In the same cycle that `supply_ok` falls, `tx_path_en` and `bus_pull_dom` go to 0 without waiting for a clock edge.
- R4: In sleep (2'b01), a 1 on `wake_bus` or `wake_pin` at a rising edge moves the mode to awake. If the synchronised enable is also 1 at that edge, the mode moves to normal instead.
- R5: In sleep, a synchronised enable of 1 moves the mode straight to normal (2'b11). A change on `en_async` reaches the mode at the third rising edge after the change and not earlier.
- R6: The awake state moves to normal only when the synchronised enable is 1. Wake requests in the awake state leave the mode unchanged.
- R7: In normal, a synchronised enable of 0 moves the mode to sleep.
- R8: `inh_out` is 1 in awake and normal, and 0 in sleep and power-down.
- R9: `rxd_oe` is 0 in sleep and power-down (the pin floats). In awake, `rxd_oe`=1 and `rxd_out`=0. In normal, `rxd_oe`=1 and `rxd_out` equals `bus_level`, so a dominant bus reads as 0.
- R10: `bus_pull_dom` is 1 only when the mode is normal, `supply_ok`=1 and `txd_in`=0. `tx_path_en` is 1 exactly in normal with `supply_ok`=1.
- R11: `txd_pu_en` is 1 in awake and normal, and 0 in sleep and power-down.
- R12: The `mode` encoding is 2'b00 power-down, 2'b01 sleep, 2'b10 awake, 2'b11 normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Battery supply above the operating threshold |
| en_async | input | 1 | Host enable, asynchronous |
| wake_bus | input | 1 | Wake request from the bus wake detector |
| wake_pin | input | 1 | Wake request from the filtered wake pin |
| txd_in | input | 1 | Transmit data from the host (0 = dominant) |
| bus_level | input | 1 | Digitised bus level (1 = recessive) |
| tx_path_en | output | 1 | Transmit path enabled |
| bus_pull_dom | output | 1 | Command to pull the bus dominant |
| rxd_out | output | 1 | Receive data to the host |
| rxd_oe | output | 1 | Receive pin output enable |
| inh_out | output | 1 | Regulator inhibit control (1 = regulator on) |
| txd_pu_en | output | 1 | Pull-up enable on the transmit input |
| mode | output | 2 | Current mode code |

## Verification
The assertions check on every cycle that a supply drop forces power-down, that power-up always lands in awake, that a wake in sleep never leaves the block in sleep, that awake holds the receive pin low, and that the bus is pulled dominant only under the normal-mode conditions. Only the bench scenarios can show the three-edge latency of the enable synchroniser, the priority of a local enable over a simultaneous wake, and the full output table. For each mode, the bench sweeps every combination of `txd_in` and `bus_level`.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en_async,
  input  logic       wake_bus,
  input  logic       wake_pin,
  input  logic       txd_in,
  input  logic       bus_level,
  output logic       tx_path_en,
  output logic       bus_pull_dom,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       inh_out,
  output logic       txd_pu_en,
  output logic [1:0] mode
);

  localparam logic [1:0] M_OFF   = 2'b00;
  localparam logic [1:0] M_SLEEP = 2'b01;
  localparam logic [1:0] M_AWAKE = 2'b10;
  localparam logic [1:0] M_RUN   = 2'b11;

  logic [SYNC_STAGES-1:0] en_pipe;
  logic                   en_s;
  logic [1:0]             st, st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_pipe <= '0;
    else        en_pipe <= {en_pipe[SYNC_STAGES-2:0], en_async};

  assign en_s = en_pipe[SYNC_STAGES-1];

  always_comb begin
    st_nx = st;
    if (!supply_ok) st_nx = M_OFF;
    else begin
      case (st)
        M_OFF:   st_nx = M_AWAKE;
        M_SLEEP: if (en_s) st_nx = M_RUN;
                 else if (wake_bus || wake_pin) st_nx = M_AWAKE;
        M_AWAKE: if (en_s) st_nx = M_RUN;
        M_RUN:   if (!en_s) st_nx = M_SLEEP;
        default: st_nx = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= M_OFF;
    else        st <= st_nx;

  assign mode         = st;
  assign tx_path_en   = (st == M_RUN) && supply_ok;
  assign bus_pull_dom = tx_path_en && !txd_in;
  assign inh_out      = (st == M_AWAKE) || (st == M_RUN);
  assign txd_pu_en    = inh_out;
  assign rxd_oe       = inh_out;
  assign rxd_out      = (st == M_RUN) ? bus_level : 1'b0;

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       wake_bus,
  input logic       wake_pin,
  input logic       txd_in,
  input logic       bus_pull_dom,
  input logic       rxd_out,
  input logic       rxd_oe,
  input logic [1:0] mode
);

  a_r3_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> mode == 2'b00);

  a_r2_powerup_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && supply_ok) |=> mode == 2'b10);

  a_r4_wake_leaves_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && supply_ok && (wake_bus || wake_pin)) |=> mode[1]);

  a_r9_awake_rxd_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> (rxd_oe && !rxd_out));

  a_r10_dom_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull_dom |-> (mode == 2'b11 && supply_ok && !txd_in));

  a_r6_awake_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> mode != 2'b01);

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wake_bus(wake_bus),
  .wake_pin(wake_pin), .txd_in(txd_in), .bus_pull_dom(bus_pull_dom),
  .rxd_out(rxd_out), .rxd_oe(rxd_oe), .mode(mode)
);

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
  logic clk = 0, rst_n = 0, supply_ok = 0, en_async = 0;
  logic wake_bus = 0, wake_pin = 0, txd_in = 1, bus_level = 1;
  logic tx_path_en, bus_pull_dom, rxd_out, rxd_oe, inh_out, txd_pu_en;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lin_mode_ctrl u_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_async(en_async),
    .wake_bus(wake_bus), .wake_pin(wake_pin), .txd_in(txd_in),
    .bus_level(bus_level), .tx_path_en(tx_path_en), .bus_pull_dom(bus_pull_dom),
    .rxd_out(rxd_out), .rxd_oe(rxd_oe), .inh_out(inh_out),
    .txd_pu_en(txd_pu_en), .mode(mode));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sweep(input logic [1:0] m);
    chk("R12 mode", mode, m);
    for (int v = 0; v < 4; v++) begin
      txd_in = v[0]; bus_level = v[1];
      #1;
      chk("R8 inh", inh_out, (m >= 2) ? 1 : 0);
      chk("R11 pullup", txd_pu_en, (m >= 2) ? 1 : 0);
      chk("R9 rxd_oe", rxd_oe, (m >= 2) ? 1 : 0);
      if (m >= 2) chk("R9 rxd", rxd_out, (m == 3) ? v[1] : 0);
      chk("R10 tx_en", tx_path_en, (m == 3 && supply_ok) ? 1 : 0);
      chk("R10 drive", bus_pull_dom, (m == 3 && supply_ok && !v[0]) ? 1 : 0);
    end
    txd_in = 1; bus_level = 1;
  endtask

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    sweep(2'b00);                       // R1 reset state
    rst_n = 1; tick(3);
    chk("R2 stays off without supply", mode, 0);
    supply_ok = 1; tick(1);
    chk("R2 power-up to awake", mode, 2);
    sweep(2'b10);
    wake_pin = 1; wake_bus = 1; tick(2); wake_pin = 0; wake_bus = 0;
    chk("R6 wake ignored in awake", mode, 2);
    en_async = 1; tick(2);
    chk("R5 enable latency not yet", mode, 2);
    tick(1);
    chk("R6 awake to normal", mode, 3);
    sweep(2'b11);
    en_async = 0; tick(2);
    chk("R7 latency", mode, 3);
    tick(1);
    chk("R7 normal to sleep", mode, 1);
    sweep(2'b01);
    tick(4);
    chk("R4 sleep holds without wake", mode, 1);
    wake_bus = 1; tick(1); wake_bus = 0;
    chk("R4 bus wake", mode, 2);
    en_async = 1; tick(3); en_async = 0; tick(3);
    chk("R7 back to sleep", mode, 1);
    wake_pin = 1; tick(1); wake_pin = 0;
    chk("R4 pin wake", mode, 2);
    en_async = 1; tick(3); en_async = 0; tick(3);
    chk("R7 sleep again", mode, 1);
    en_async = 1; tick(2);
    chk("R5 not before third edge", mode, 1);
    tick(1);
    chk("R5 local wake to normal", mode, 3);
    en_async = 0; tick(3);
    chk("R7 sleep", mode, 1);
    en_async = 1; tick(2); wake_bus = 1; tick(1); wake_bus = 0;
    chk("R4 enable beats wake", mode, 3);
    txd_in = 0; #1;
    chk("R10 dominant drive", bus_pull_dom, 1);
    supply_ok = 0; #1;
    chk("R3 immediate drive off", bus_pull_dom, 0);
    chk("R3 immediate path off", tx_path_en, 0);
    chk("R3 mode before edge", mode, 3);
    tick(1);
    chk("R3 normal to off", mode, 0);
    sweep(2'b00);
    supply_ok = 1; tick(1);
    chk("R2 awake even with enable", mode, 2);
    tick(1);
    chk("R6 then normal", mode, 3);
    en_async = 0; tick(3);
    supply_ok = 0; tick(1);
    chk("R3 sleep to off", mode, 0);
    supply_ok = 1; tick(1);
    supply_ok = 0; tick(1);
    chk("R3 awake to off", mode, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule